// File: doc/BRIEF.md
# Multitask Branch Unit with Per-Task Execution Mode

This unit keeps the program counters for a set of hardware tasks that share one core. Each task holds a 16-bit fetch address and a one-bit execution mode. Mode 0 means the task fetches from the 512-word local register RAM. Mode 1 means it fetches from shared main memory. The decoder passes the unit one resolved control-flow request per cycle: a jump, a call or a return, for one task, with its condition already evaluated. The unit updates that task's fetch address and mode, and raises a cancel pulse for that task alone.

The mode bit moves with the control flow. Any jump or call can carry a flag that flips the mode at the destination. A call saves the caller's mode together with its return address on a small per-task return stack. A return restores both values, so code in local RAM and code in main memory can call each other freely. An immediate target is an absolute local address while the task runs locally. When the task runs from main memory, the same immediate becomes a signed offset from the current address. Explicit relative forms exist in both modes.

A launch command sets a new address and a per-task mode for any subset of tasks, so a task can start directly in main memory. Nothing outside these operations can read or write the counters.

Top module: `task_branch_unit`

## Requirements
- R1: After reset every task has fetch address 0, mode 0 (local), and no flush or underflow pulse.
- R2: An `adv` bit with no other operation for that task adds 1 to its address. In local mode the address wraps within 9 bits (0x1FF to 0x000) and bits 15:9 stay zero. In mode 1 it wraps modulo 2^16.
- R3: In local mode, an immediate jump or call with `req_rel`=0 goes to `req_target[8:0]` zero-extended.
- R4: An immediate jump or call in mode 1, or any immediate one with `req_rel`=1, goes to the current address plus `req_target[8:0]` sign-extended, modulo 2^16 (then reduced to 9 bits if the destination mode is local).
- R5: A jump or call with `req_imm`=0 goes to the full 16-bit `req_target`, reduced to its low 9 bits when the destination mode is local.
- R6: The destination mode of a jump or call is the current mode XOR `req_toggle`. With `req_toggle`=0 the mode is unchanged.
- R7: A call pushes {caller mode, address+1 (wrapped as in R2)}. A return pops the most recent entry and restores both the address and the mode. `req_toggle` has no effect on a return.
- R8: Each task's return stack holds 4 entries. A push onto a full stack discards the oldest entry.
- R9: A return on an empty stack sets the address to 0 and the mode to local, and pulses that task's `underflow` for one cycle.
- R10: A request with `req_valid`=1, `req_cond`=1 and `req_op`!=0 pulses `flush` for the selected task only, in the cycle after the request. A request with `req_cond`=0 or `req_op`=0 changes no task and raises no flush. Op codes: 0 none, 1 jump, 2 call, 3 return.
- R11: A launch sets every task whose `launch_mask` bit is 1 to `launch_pc` with mode `launch_mode[t]`, reduced to 9 bits when that mode is local. It empties that task's return stack, overrides any request or advance for that task in the same cycle, and raises no flush.
- R12: A request for one task leaves the addresses and modes of all other tasks to their own advance inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A resolved control-flow request is present |
| req_task | input | 2 | Task issuing the request |
| req_op | input | 2 | 0 none, 1 jump, 2 call, 3 return |
| req_cond | input | 1 | Branch condition met (taken) |
| req_imm | input | 1 | Target is a 9-bit immediate |
| req_rel | input | 1 | Explicit relative form |
| req_toggle | input | 1 | Flip execution mode at the destination |
| req_target | input | 16 | Register target, or immediate in bits 8:0 |
| adv | input | 4 | Sequential advance per task |
| launch_valid | input | 1 | Launch command present |
| launch_mask | input | 4 | Tasks selected by the launch |
| launch_mode | input | 4 | Start mode per task |
| launch_pc | input | 16 | Start address |
| fetch_pc | output | 64 | Per-task fetch address, task t in bits 16t+15:16t |
| fetch_mode | output | 4 | Per-task execution mode |
| flush | output | 4 | One-cycle cancel of the task's fetched instruction |
| underflow | output | 4 | One-cycle return-stack underflow pulse |

## Verification
The bench builds the unit with its default parameters: four tasks, a 9-bit local space, 9-bit offsets and a return stack four deep. A depth of four means five nested calls are enough to reach the overwrite of the oldest entry and the later underflow on return. The 9-bit local space puts the local wrap point at 0x1FF, and the 16-bit address puts the main-memory wrap at 0xFFFF, so both wrap points can be reached with short offsets. With four tasks and a 2-bit task selector, every issuer slot can be checked against the other three in the mixed random phase.

// File: rtl/mtbu_pkg.sv
package mtbu_pkg;

    localparam int PC_W = 16;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } br_op_e;

    typedef enum logic {
        XM_LOCAL = 1'b0,
        XM_MAIN  = 1'b1
    } xmode_e;

    typedef struct packed {
        xmode_e            mode;
        logic [PC_W-1:0]   pc;
    } ret_entry_t;

    // Reduce an address to the local window when the mode is local.
    function automatic logic [PC_W-1:0] fit_pc(
        input logic [PC_W-1:0] pc,
        input xmode_e          mode,
        input logic [PC_W-1:0] local_mask
    );
        return (mode == XM_LOCAL) ? (pc & local_mask) : pc;
    endfunction

endpackage

// File: rtl/mtbu_target.sv
module mtbu_target
    import mtbu_pkg::*;
#(
    parameter int LOCAL_AW = 9,
    parameter int OFF_W    = 9
) (
    input  logic [PC_W-1:0] pc_i,
    input  xmode_e          mode_i,
    input  logic            imm_i,
    input  logic            rel_i,
    input  logic            toggle_i,
    input  logic [PC_W-1:0] tgt_i,
    output logic [PC_W-1:0] dest_pc_o,
    output xmode_e          dest_mode_o
);
    localparam logic [PC_W-1:0] LOCAL_MASK = (PC_W'(1) << LOCAL_AW) - PC_W'(1);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] abs_imm;
    logic [PC_W-1:0] raw_pc;
    logic            use_rel;

    assign off_ext = {{(PC_W-OFF_W){tgt_i[OFF_W-1]}}, tgt_i[OFF_W-1:0]};
    assign abs_imm = {{(PC_W-OFF_W){1'b0}}, tgt_i[OFF_W-1:0]};
    assign use_rel = rel_i || (mode_i == XM_MAIN);

    always_comb begin
        if (imm_i) begin
            raw_pc = use_rel ? (pc_i + off_ext) : abs_imm;
        end else begin
            raw_pc = tgt_i;
        end
        dest_mode_o = xmode_e'(mode_i ^ toggle_i);
        dest_pc_o   = fit_pc(raw_pc, dest_mode_o, LOCAL_MASK);
    end

endmodule

// File: rtl/mtbu_rstack.sv
module mtbu_rstack
    import mtbu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       push_i,
    input  logic       pop_i,
    input  ret_entry_t push_data_i,
    output ret_entry_t top_o,
    output logic       empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    ret_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] nxt_ptr;
    logic [PTR_W-1:0] prv_ptr;
    logic [CNT_W-1:0] count;

    assign nxt_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
    assign prv_ptr = (wr_ptr == '0) ? LAST : wr_ptr - PTR_W'(1);
    assign top_o   = slots[prv_ptr];
    assign empty_o = (count == '0);

    always_ff @(posedge clk) begin
        if (push_i && !clear_i) begin
            slots[wr_ptr] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push_i) begin
            wr_ptr <= nxt_ptr;
            if (count != FULL) begin
                count <= count + CNT_W'(1);
            end
        end else if (pop_i && count != '0) begin
            wr_ptr <= prv_ptr;
            count  <= count - CNT_W'(1);
        end
    end

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL); // R8
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push_i && !clear_i && count < FULL) |=> (count == $past(count) + CNT_W'(1))); // R8
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (push_i && !clear_i && count == FULL) |=> (count == FULL)); // R8

endmodule

// File: rtl/mtbu_task.sv
module mtbu_task
    import mtbu_pkg::*;
#(
    parameter int LOCAL_AW    = 9,
    parameter int OFF_W       = 9,
    parameter int STACK_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch_hit_i,
    input  logic [PC_W-1:0] launch_pc_i,
    input  xmode_e          launch_mode_i,
    input  logic            req_hit_i,
    input  br_op_e          req_op_i,
    input  logic            req_imm_i,
    input  logic            req_rel_i,
    input  logic            req_toggle_i,
    input  logic [PC_W-1:0] req_tgt_i,
    input  logic            adv_i,
    output logic [PC_W-1:0] pc_o,
    output xmode_e          mode_o,
    output logic            flush_o,
    output logic            underflow_o
);
    localparam logic [PC_W-1:0] LOCAL_MASK = (PC_W'(1) << LOCAL_AW) - PC_W'(1);

    logic [PC_W-1:0] pc_q;
    xmode_e          mode_q;
    logic            flush_q;
    logic            uf_q;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] dest_pc;
    xmode_e          dest_mode;
    ret_entry_t      push_entry;
    ret_entry_t      top_entry;
    logic            stk_empty;
    logic            do_push;
    logic            do_pop;

    assign seq_pc     = fit_pc(pc_q + PC_W'(1), mode_q, LOCAL_MASK);
    assign push_entry = '{mode: mode_q, pc: seq_pc};
    assign do_push    = req_hit_i && (req_op_i == BR_CALL) && !launch_hit_i;
    assign do_pop     = req_hit_i && (req_op_i == BR_RET)  && !launch_hit_i;

    mtbu_target #(
        .LOCAL_AW (LOCAL_AW),
        .OFF_W    (OFF_W)
    ) u_target (
        .pc_i        (pc_q),
        .mode_i      (mode_q),
        .imm_i       (req_imm_i),
        .rel_i       (req_rel_i),
        .toggle_i    (req_toggle_i),
        .tgt_i       (req_tgt_i),
        .dest_pc_o   (dest_pc),
        .dest_mode_o (dest_mode)
    );

    mtbu_rstack #(
        .DEPTH (STACK_DEPTH)
    ) u_rstack (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (launch_hit_i),
        .push_i      (do_push),
        .pop_i       (do_pop),
        .push_data_i (push_entry),
        .top_o       (top_entry),
        .empty_o     (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            mode_q  <= XM_LOCAL;
            flush_q <= 1'b0;
            uf_q    <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            uf_q    <= 1'b0;
            if (launch_hit_i) begin
                pc_q   <= fit_pc(launch_pc_i, launch_mode_i, LOCAL_MASK);
                mode_q <= launch_mode_i;
            end else if (req_hit_i) begin
                flush_q <= 1'b1;
                case (req_op_i)
                    BR_JUMP, BR_CALL: begin
                        pc_q   <= dest_pc;
                        mode_q <= dest_mode;
                    end
                    BR_RET: begin
                        if (stk_empty) begin
                            pc_q   <= '0;
                            mode_q <= XM_LOCAL;
                            uf_q   <= 1'b1;
                        end else begin
                            pc_q   <= top_entry.pc;
                            mode_q <= top_entry.mode;
                        end
                    end
                    default: ;
                endcase
            end else if (adv_i) begin
                pc_q <= seq_pc;
            end
        end
    end

    assign pc_o        = pc_q;
    assign mode_o      = mode_q;
    assign flush_o     = flush_q;
    assign underflow_o = uf_q;

    AST_LOCAL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == XM_LOCAL) |-> ((pc_q & ~LOCAL_MASK) == '0)); // R2
    AST_UNDERFLOW_HOME: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> (pc_q == '0 && mode_q == XM_LOCAL)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!launch_hit_i && !req_hit_i && !adv_i) |=> ($stable(pc_q) && $stable(mode_q))); // R12
    AST_LAUNCH_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        launch_hit_i |=> !flush_q); // R11

endmodule

// File: rtl/task_branch_unit.sv
module task_branch_unit
    import mtbu_pkg::*;
#(
    parameter int NUM_TASKS   = 4,
    parameter int LOCAL_AW    = 9,
    parameter int OFF_W       = 9,
    parameter int STACK_DEPTH = 4,
    localparam int TID_W      = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [TID_W-1:0]          req_task,
    input  logic [1:0]                req_op,
    input  logic                      req_cond,
    input  logic                      req_imm,
    input  logic                      req_rel,
    input  logic                      req_toggle,
    input  logic [PC_W-1:0]           req_target,
    input  logic [NUM_TASKS-1:0]      adv,
    input  logic                      launch_valid,
    input  logic [NUM_TASKS-1:0]      launch_mask,
    input  logic [NUM_TASKS-1:0]      launch_mode,
    input  logic [PC_W-1:0]           launch_pc,
    output logic [NUM_TASKS*PC_W-1:0] fetch_pc,
    output logic [NUM_TASKS-1:0]      fetch_mode,
    output logic [NUM_TASKS-1:0]      flush,
    output logic [NUM_TASKS-1:0]      underflow
);
    br_op_e op_dec;
    logic   req_taken;

    assign op_dec    = br_op_e'(req_op);
    assign req_taken = req_valid && req_cond && (op_dec != BR_NONE);

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
        logic   req_hit;
        logic   launch_hit;
        xmode_e mode_out;

        assign req_hit    = req_taken && (req_task == TID_W'(g));
        assign launch_hit = launch_valid && launch_mask[g];

        mtbu_task #(
            .LOCAL_AW    (LOCAL_AW),
            .OFF_W       (OFF_W),
            .STACK_DEPTH (STACK_DEPTH)
        ) u_task (
            .clk           (clk),
            .rst           (rst),
            .launch_hit_i  (launch_hit),
            .launch_pc_i   (launch_pc),
            .launch_mode_i (xmode_e'(launch_mode[g])),
            .req_hit_i     (req_hit),
            .req_op_i      (op_dec),
            .req_imm_i     (req_imm),
            .req_rel_i     (req_rel),
            .req_toggle_i  (req_toggle),
            .req_tgt_i     (req_target),
            .adv_i         (adv[g]),
            .pc_o          (fetch_pc[g*PC_W +: PC_W]),
            .mode_o        (mode_out),
            .flush_o       (flush[g]),
            .underflow_o   (underflow[g])
        );

        assign fetch_mode[g] = mode_out;
    end

    AST_FLUSH_SOLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flush)); // R10
    AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!req_taken) |=> (flush == '0)); // R10

endmodule

// File: tb/task_branch_unit_tb.sv
module task_branch_unit_tb;

    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_cond, req_imm, req_rel, req_toggle;
    logic [1:0]  req_task, req_op;
    logic [15:0] req_target;
    logic [3:0]  adv;
    logic        launch_valid;
    logic [3:0]  launch_mask, launch_mode;
    logic [15:0] launch_pc;
    logic [63:0] fetch_pc;
    logic [3:0]  fetch_mode, flush, underflow;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    int m_pc [NT];
    int m_mode [NT];
    int m_fl [NT];
    int m_uf [NT];
    int m_cnt [NT];
    int m_stk [NT][4];

    always #4 clk = ~clk;

    task_branch_unit u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_task(req_task), .req_op(req_op),
        .req_cond(req_cond), .req_imm(req_imm), .req_rel(req_rel),
        .req_toggle(req_toggle), .req_target(req_target), .adv(adv),
        .launch_valid(launch_valid), .launch_mask(launch_mask),
        .launch_mode(launch_mode), .launch_pc(launch_pc),
        .fetch_pc(fetch_pc), .fetch_mode(fetch_mode),
        .flush(flush), .underflow(underflow)
    );

    function automatic int fit(input int pc, input int md);
        return md ? (pc & 16'hFFFF) : (pc & 16'h01FF);
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_task = 0; req_op = 0; req_cond = 1;
        req_imm = 0; req_rel = 0; req_toggle = 0; req_target = 0;
        adv = 0; launch_valid = 0; launch_mask = 0; launch_mode = 0; launch_pc = 0;
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_pc[t] = 0; m_mode[t] = 0; m_fl[t] = 0; m_uf[t] = 0; m_cnt[t] = 0;
        end
    endtask

    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            bit lh, rh;
            lh = launch_valid && launch_mask[t];
            rh = req_valid && req_cond && req_op != 0 && req_task == t;
            m_fl[t] = 0; m_uf[t] = 0;
            if (lh) begin
                m_mode[t] = launch_mode[t];
                m_pc[t] = fit(launch_pc, m_mode[t]);
                m_cnt[t] = 0;
            end else if (rh) begin
                m_fl[t] = 1;
                if (req_op == 3) begin
                    if (m_cnt[t] == 0) begin
                        m_pc[t] = 0; m_mode[t] = 0; m_uf[t] = 1;
                    end else begin
                        m_cnt[t]--;
                        m_mode[t] = m_stk[t][m_cnt[t]] >> 16;
                        m_pc[t] = m_stk[t][m_cnt[t]] & 16'hFFFF;
                    end
                end else begin
                    int off, raw, nm;
                    off = req_target[8:0];
                    if (off >= 256) off -= 512;
                    if (req_imm) begin
                        if (req_rel || m_mode[t] == 1) raw = (m_pc[t] + off) & 16'hFFFF;
                        else raw = req_target & 16'h01FF;
                    end else begin
                        raw = req_target;
                    end
                    nm = m_mode[t] ^ req_toggle;
                    if (req_op == 2) begin
                        if (m_cnt[t] == 4) begin
                            for (int k = 0; k < 3; k++) m_stk[t][k] = m_stk[t][k+1];
                            m_cnt[t] = 3;
                        end
                        m_stk[t][m_cnt[t]] = (m_mode[t] << 16) | fit(m_pc[t] + 1, m_mode[t]);
                        m_cnt[t]++;
                    end
                    m_mode[t] = nm;
                    m_pc[t] = fit(raw, nm);
                end
            end else if (adv[t]) begin
                m_pc[t] = fit(m_pc[t] + 1, m_mode[t]);
            end
        end
    endtask

    task automatic compare();
        for (int t = 0; t < NT; t++) begin
            int apc, am, af, au;
            apc = fetch_pc[t*16 +: 16]; am = fetch_mode[t]; af = flush[t]; au = underflow[t];
            tests++;
            if (apc != m_pc[t] || am != m_mode[t] || af != m_fl[t] || au != m_uf[t]) begin
                fails++;
                $display("FAIL %s task%0d: actual pc=%h mode=%0d flush=%0d uf=%0d expected pc=%h mode=%0d flush=%0d uf=%0d",
                         cur_req, t, apc, am, af, au, m_pc[t], m_mode[t], m_fl[t], m_uf[t]);
            end
        end
    endtask

    // one clock: model sees the inputs driven before the edge
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic branch(input int tk, input int op, input bit imm, input bit rel,
                          input bit tog, input int tgt);
        req_valid = 1; req_task = 2'(tk); req_op = 2'(op); req_cond = 1;
        req_imm = imm; req_rel = rel; req_toggle = tog; req_target = 16'(tgt);
        tick();
    endtask

    task automatic launch(input int mask, input int modes, input int pc);
        launch_valid = 1; launch_mask = 4'(mask); launch_mode = 4'(modes); launch_pc = 16'(pc);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cur_req = "R1"; compare();
        tick();

        // R2: local wrap at 0x1FF, main wrap at 0xFFFF
        cur_req = "R11"; launch(4'b0011, 4'b0010, 16'hFFFE);
        cur_req = "R2";
        for (int i = 0; i < 4; i++) begin adv = 4'b0011; tick(); end

        // R3: absolute immediate in local mode (task0 local)
        cur_req = "R3"; branch(0, 1, 1, 0, 0, 16'hFF55);
        // R4: main-mode immediate is relative, negative offset (task1 main)
        cur_req = "R4"; branch(1, 1, 1, 0, 0, 16'h01F0);
        cur_req = "R4"; branch(1, 1, 1, 0, 0, 16'h0020);
        cur_req = "R4"; branch(0, 1, 1, 1, 0, 16'h01F0);
        cur_req = "R4"; branch(0, 1, 1, 1, 0, 16'h00F0);
        // R5: register target, masked in local
        cur_req = "R5"; branch(2, 1, 0, 0, 0, 16'hABCD);
        cur_req = "R5"; branch(1, 1, 0, 0, 0, 16'hABCD);
        // R6: toggled jumps both ways
        cur_req = "R6"; branch(2, 1, 0, 0, 1, 16'h8123);
        cur_req = "R6"; branch(2, 1, 1, 0, 1, 16'h0004);
        cur_req = "R6"; branch(2, 1, 1, 0, 0, 16'h0004);

        // R7: call local->main, return restores local
        cur_req = "R7"; branch(3, 1, 1, 0, 0, 16'h01FF);
        cur_req = "R7"; branch(3, 2, 0, 0, 1, 16'h4000);
        adv = 4'b1000; tick();
        cur_req = "R7"; branch(3, 3, 0, 0, 1, 16'h0000);
        // call main->local and back
        cur_req = "R7"; branch(1, 2, 0, 0, 1, 16'h0077);
        cur_req = "R7"; branch(1, 3, 0, 0, 0, 16'h0000);

        // R8/R9: five nested calls, five returns
        cur_req = "R8";
        for (int i = 0; i < 5; i++) branch(0, 2, 1, 0, i[0], 16'h0010 + i);
        for (int i = 0; i < 4; i++) branch(0, 3, 0, 0, 0, 0);
        cur_req = "R9"; branch(0, 3, 0, 0, 0, 0);
        tick();

        // R10: not-taken and op-none requests change nothing
        cur_req = "R10";
        req_valid = 1; req_task = 1; req_op = 1; req_cond = 0; req_target = 16'h1234; tick();
        req_valid = 1; req_task = 2; req_op = 0; req_cond = 1; req_target = 16'h1234; tick();

        // R11: launch overrides a same-cycle branch, empties stack
        cur_req = "R11";
        branch(2, 2, 0, 0, 0, 16'h0100);
        launch_valid = 1; launch_mask = 4'b0101; launch_mode = 4'b0100; launch_pc = 16'hC3A5;
        req_valid = 1; req_task = 2; req_op = 1; req_target = 16'h0033; adv = 4'b1111;
        tick();
        branch(2, 3, 0, 0, 0, 0);

        // R12: mixed random traffic
        cur_req = "R12";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            adv = 4'($urandom);
            if (r < 6) begin
                req_valid = 1; req_task = 2'($urandom); req_op = 2'($urandom);
                req_cond = ($urandom_range(0, 3) != 0); req_imm = 1'($urandom);
                req_rel = 1'($urandom); req_toggle = 1'($urandom); req_target = 16'($urandom);
            end else if (r == 6) begin
                launch_valid = 1; launch_mask = 4'($urandom); launch_mode = 4'($urandom);
                launch_pc = 16'($urandom);
            end
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule